// File: doc/BRIEF.md
# Partial Reconfiguration Load Watcher

This block sits in the 32-bit word path between a bitstream source and an internal configuration port. Every word is forwarded through a single register stage with a valid/ready handshake in both directions. The block also reads each word as the downstream port accepts it. It uses those words to report whether a reconfigurable region is being rewritten and when that region may be handed back to the user logic. The rest of the device keeps running during a load. Only the targeted region is held isolated.

A load opens when the synchronization word is accepted downstream. It closes when the desynchronize command is accepted. No length count is used, and the block neither expects nor produces any startup sequence after the closing word. A paired mode can be selected at the opening of a load. In that mode a clearing stream and the partial stream that follows it count as one load, so the region stays isolated and the done flag stays low across the gap between them. Two things end a load early: a second sync word before the close, or an abort request. Either one sets a sticky fault, and the region stays isolated until a soft clear.

Top module: `pr_load_watch`

## Requirements
- R1: A word accepted at the input (in_valid and in_ready both high at a rising edge) appears unchanged on out_word with out_valid high in the following cycle. Words leave in the order they arrived.
- R2: While out_valid is high and out_ready is low, in_ready is low and out_word holds its value.
- R3: After reset, done=1, busy=0, isolate=0 and fault=0. While no load is open, words other than the sync word 32'hAA995566 leave all four status outputs unchanged.
- R4: In the cycle after the sync word 32'hAA995566 is accepted downstream (out_valid and out_ready high), busy=1, done=0 and isolate=1.
- R5: In single mode, in the cycle after the desynchronize word 32'h0000000D is accepted downstream, busy=0, done=1 and isolate=0. Padding no-operation words such as 32'h20000000 inside a load leave the status unchanged.
- R6: When paired_mode is high as the opening sync word is accepted, the first desynchronize word leaves busy=1, done=0 and isolate=1. The next sync word continues the same load. Only the desynchronize word of that second stream gives done=1 and isolate=0.
- R7: A sync word accepted downstream while a load is open sets fault=1. In the next cycle busy=0, done=0 and isolate=1, and the outputs keep these values until soft_clr.
- R8: Asserting abort while a load is open sets fault in the same way as R7. Asserting abort while no load is open has no effect.
- R9: soft_clr returns the block to the post-reset status of R3 from any state.
- R10: A word counts only when it is accepted downstream. A desynchronize word held on the output while out_ready is low does not release isolate. The release happens one cycle after out_ready lets the word through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_clr | input | 1 | Synchronous clear of load state and fault |
| abort | input | 1 | Request to abandon the open load |
| paired_mode | input | 1 | Treat clearing plus partial stream as one load; sampled at the opening sync |
| in_word | input | 32 | Configuration word from the source |
| in_valid | input | 1 | in_word is valid |
| in_ready | output | 1 | Block can take a word |
| out_word | output | 32 | Word toward the configuration port |
| out_valid | output | 1 | out_word is valid |
| out_ready | input | 1 | Configuration port takes the word |
| busy | output | 1 | A load is in progress |
| done | output | 1 | No load pending and no fault |
| isolate | output | 1 | Keep the reconfigurable region isolated |
| fault | output | 1 | Sticky error: resync or abort during a load |

## Verification
The bench runs every load length from zero to five padding words in both single and paired mode, and checks the status after each word. A design that counted words instead of watching for the closing command would release too early or too late in this sweep. A design that ignored the pairing would raise done at the end of the clearing stream. The bench also holds a desynchronize word on the output under backpressure. A design that snooped at the input instead of at the downstream acceptance would drop isolate while the word still sat in the register. Resync and abort are tried both inside and outside a load. A fault that was not sticky, or an abort that was honoured while idle, shows up as a wrong fault or done value.

// File: rtl/pr_load_watch_pkg.sv
`timescale 1ns/1ps
package pr_load_watch_pkg;
  localparam int unsigned WORD_W = 32;
  localparam logic [WORD_W-1:0] SYNC_CODE   = 32'hAA995566;
  localparam logic [WORD_W-1:0] DESYNC_CODE = 32'h0000000D;

  typedef enum logic [2:0] {
    LW_IDLE   = 3'd0,
    LW_LOAD   = 3'd1,
    LW_GAP    = 3'd2,
    LW_CLOSED = 3'd3,
    LW_FAULT  = 3'd4
  } lw_state_e;
endpackage

// File: rtl/lw_word_stage.sv
`timescale 1ns/1ps
module lw_word_stage #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] up_word,
  input  logic         up_valid,
  output logic         up_ready,
  output logic [W-1:0] dn_word,
  output logic         dn_valid,
  input  logic         dn_ready
);
  logic [W-1:0] word_q;
  logic         full_q;

  assign up_ready = !full_q || dn_ready;
  assign dn_word  = word_q;
  assign dn_valid = full_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      word_q <= '0;
    end else if (up_valid && up_ready) begin
      full_q <= 1'b1;
      word_q <= up_word;
    end else if (dn_ready) begin
      full_q <= 1'b0;
    end
  end

  assert_hold_on_stall_R2: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_word)));
endmodule

// File: rtl/lw_word_classify.sv
`timescale 1ns/1ps
module lw_word_classify #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] OPEN_CODE  = '1,
  parameter logic [W-1:0] CLOSE_CODE = '0
) (
  input  logic [W-1:0] word,
  output logic         is_open,
  output logic         is_close
);
  assign is_open  = (word == OPEN_CODE);
  assign is_close = (word == CLOSE_CODE);
endmodule

// File: rtl/lw_load_fsm.sv
`timescale 1ns/1ps
module lw_load_fsm
  import pr_load_watch_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic soft_clr,
  input  logic abort,
  input  logic paired_mode,
  input  logic take,
  input  logic is_open,
  input  logic is_close,
  output logic busy,
  output logic done,
  output logic isolate,
  output logic fault
);
  lw_state_e st_q, st_d;
  logic      pair_q, pair_d;
  logic      busy_q, done_q, iso_q, fault_q;

  always_comb begin
    st_d   = st_q;
    pair_d = pair_q;
    unique case (st_q)
      LW_IDLE, LW_CLOSED: begin
        if (take && is_open) begin
          st_d   = LW_LOAD;
          pair_d = paired_mode;
        end
      end
      LW_LOAD: begin
        if (abort || (take && is_open)) begin
          st_d = LW_FAULT;
        end else if (take && is_close) begin
          st_d   = pair_q ? LW_GAP : LW_CLOSED;
          pair_d = 1'b0;
        end
      end
      LW_GAP: begin
        if (abort) st_d = LW_FAULT;
        else if (take && is_open) st_d = LW_LOAD;
      end
      LW_FAULT: st_d = LW_FAULT;
      default:  st_d = LW_IDLE;
    endcase
    if (soft_clr) begin
      st_d   = LW_IDLE;
      pair_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= LW_IDLE;
      pair_q  <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b1;
      iso_q   <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      pair_q  <= pair_d;
      busy_q  <= (st_d == LW_LOAD) || (st_d == LW_GAP);
      done_q  <= (st_d == LW_IDLE) || (st_d == LW_CLOSED);
      iso_q   <= (st_d == LW_LOAD) || (st_d == LW_GAP) || (st_d == LW_FAULT);
      fault_q <= (st_d == LW_FAULT);
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign isolate = iso_q;
  assign fault   = fault_q;

  assert_open_isolates_R4: assert property (@(posedge clk) disable iff (rst)
    ((st_q == LW_IDLE) && take && is_open && !soft_clr) |=> (isolate && busy && !done));
  assert_release_after_close_R5: assert property (@(posedge clk) disable iff (rst)
    ((st_q == LW_LOAD) && !pair_q && take && is_close && !is_open && !abort && !soft_clr)
      |=> (!isolate && done));
  assert_gap_keeps_low_R6: assert property (@(posedge clk) disable iff (rst)
    (st_q == LW_GAP) |-> (!done && isolate));
  assert_fault_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (fault && !soft_clr) |=> (fault && isolate && !done));
  assert_idle_abort_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    ((st_q == LW_IDLE) && abort && !take && !soft_clr) |=> (!fault && done));
  assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
    soft_clr |=> (done && !isolate && !fault && !busy));
  assert_status_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, busy, fault}));
endmodule

// File: rtl/pr_load_watch.sv
`timescale 1ns/1ps
module pr_load_watch
  import pr_load_watch_pkg::*;
#(
  parameter int unsigned W = WORD_W,
  parameter logic [W-1:0] SYNC_WORD   = SYNC_CODE,
  parameter logic [W-1:0] DESYNC_WORD = DESYNC_CODE
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         soft_clr,
  input  logic         abort,
  input  logic         paired_mode,
  input  logic [W-1:0] in_word,
  input  logic         in_valid,
  output logic         in_ready,
  output logic [W-1:0] out_word,
  output logic         out_valid,
  input  logic         out_ready,
  output logic         busy,
  output logic         done,
  output logic         isolate,
  output logic         fault
);
  logic take, is_open, is_close;

  lw_word_stage #(.W(W)) stage_i (
    .clk(clk), .rst(rst),
    .up_word(in_word), .up_valid(in_valid), .up_ready(in_ready),
    .dn_word(out_word), .dn_valid(out_valid), .dn_ready(out_ready)
  );

  assign take = out_valid && out_ready;

  lw_word_classify #(.W(W), .OPEN_CODE(SYNC_WORD), .CLOSE_CODE(DESYNC_WORD)) cls_i (
    .word(out_word), .is_open(is_open), .is_close(is_close)
  );

  lw_load_fsm fsm_i (
    .clk(clk), .rst(rst), .soft_clr(soft_clr), .abort(abort),
    .paired_mode(paired_mode), .take(take), .is_open(is_open), .is_close(is_close),
    .busy(busy), .done(done), .isolate(isolate), .fault(fault)
  );

  assert_pass_through_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (out_valid && out_word == $past(in_word)));
  assert_held_close_no_release_R10: assert property (@(posedge clk) disable iff (rst)
    (isolate && out_valid && !out_ready && !soft_clr) |=> isolate);
endmodule

// File: tb/pr_load_watch_tb_top.sv
`timescale 1ns/1ps
module pr_load_watch_tb_top;
  localparam logic [31:0] SYNC   = 32'hAA995566;
  localparam logic [31:0] DESYNC = 32'h0000000D;
  localparam logic [31:0] NOOP   = 32'h20000000;

  logic clk = 1'b0;
  logic rst, soft_clr, abort, paired_mode, in_valid, out_ready;
  logic [31:0] in_word;
  logic in_ready, out_valid, busy, done, isolate, fault;
  logic [31:0] out_word;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  pr_load_watch dut_i (
    .clk(clk), .rst(rst), .soft_clr(soft_clr), .abort(abort), .paired_mode(paired_mode),
    .in_word(in_word), .in_valid(in_valid), .in_ready(in_ready),
    .out_word(out_word), .out_valid(out_valid), .out_ready(out_ready),
    .busy(busy), .done(done), .isolate(isolate), .fault(fault)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // status packed as {busy, done, isolate, fault}
  task automatic chk_st(input string tag, input logic [3:0] exp);
    chk(tag, {28'd0, busy, done, isolate, fault}, {28'd0, exp});
  endtask

  // starts and ends at a negedge; out_ready assumed high
  task automatic push(input logic [31:0] w);
    in_word  = w;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1 pass-through", {31'd0, out_valid}, 32'd1);
    chk("R1 word value", out_word, w);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; soft_clr = 1'b0; abort = 1'b0; paired_mode = 1'b0;
    in_valid = 1'b0; in_word = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_st("R3 reset state", 4'b0100);

    // R3: non-sync words while idle
    push(NOOP);   chk_st("R3 idle noop", 4'b0100);
    push(DESYNC); chk_st("R3 idle desync", 4'b0100);

    // sweep: both modes, 0..5 padding words
    for (int m = 0; m < 2; m++) begin
      for (int pad = 0; pad < 6; pad++) begin
        paired_mode = m[0];
        push(SYNC);
        paired_mode = 1'b0;
        chk_st("R4 open", 4'b1010);
        for (int k = 0; k < pad; k++) begin
          push(NOOP); chk_st("R5 padding", 4'b1010);
        end
        push(DESYNC);
        if (m == 0) begin
          chk_st("R5 close single", 4'b0100);
        end else begin
          chk_st("R6 gap after clearing stream", 4'b1010);
          push(NOOP); chk_st("R6 gap noop", 4'b1010);
          push(SYNC); chk_st("R6 second stream open", 4'b1010);
          for (int k = 0; k < pad; k++) begin
            push(NOOP); chk_st("R6 padding", 4'b1010);
          end
          push(DESYNC); chk_st("R6 close pair", 4'b0100);
        end
      end
    end

    // R2/R10: held desync under backpressure
    push(SYNC);
    out_ready = 1'b0;
    in_word = DESYNC; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 in_ready low on stall", {31'd0, in_ready}, 32'd0);
    chk("R2 word held", out_word, DESYNC);
    chk_st("R10 held desync keeps isolate", 4'b1010);
    out_ready = 1'b1;
    @(negedge clk);
    chk_st("R10 release after accept", 4'b0100);

    // R8: abort while idle ignored
    abort = 1'b1; @(negedge clk); abort = 1'b0; @(negedge clk);
    chk_st("R8 idle abort ignored", 4'b0100);

    // R8: abort during load
    push(SYNC);
    abort = 1'b1; @(negedge clk); abort = 1'b0;
    chk_st("R8 abort fault", 4'b0011);
    push(DESYNC); chk_st("R7 fault sticky after desync", 4'b0011);
    soft_clr = 1'b1; @(negedge clk); soft_clr = 1'b0;
    chk_st("R9 soft clear", 4'b0100);

    // R7: resync during load
    push(SYNC); push(NOOP);
    push(SYNC); chk_st("R7 resync fault", 4'b0011);
    push(SYNC); chk_st("R7 fault holds", 4'b0011);
    soft_clr = 1'b1; @(negedge clk); soft_clr = 1'b0;
    chk_st("R9 clear after resync", 4'b0100);

    // R9: soft clear mid-load, then a clean load
    push(SYNC);
    soft_clr = 1'b1; @(negedge clk); soft_clr = 1'b0;
    chk_st("R9 clear mid-load", 4'b0100);
    push(SYNC); push(DESYNC); chk_st("R5 load after clear", 4'b0100);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule